// File: doc/BRIEF.md
# Copy Engine Component Remapper

This block sits in the data path of a copy engine. It rearranges the components of each pixel on the fly. Source pixels arrive one per beat on a valid/ready stream. Each pixel is a byte-packed little-endian word. The block emits the remapped pixel on a second valid/ready stream.

A swizzle configuration word picks, for each of up to four destination components, one of four things:
- a source component;
- one of two programmable 32-bit constants;
- zero.

The same word sets three further things:
- the component size in bytes;
- the number of components in a source pixel;
- the number of components in a destination pixel.

Because the two counts are separate, the input and output pixel widths are independent of each other.

The configuration is written through a narrow word-addressed register port. A selection that cannot be honoured produces a zero component and raises a sticky error flag. The pipeline is a single register stage and accepts a pixel on every cycle while the output side keeps up.

Top module: `comp_remap`

## Requirements
- R1: After reset the output stream is idle (`out_valid` = 0), `in_ready` = 1, `err` = 0, and both constants and the swizzle word read as zero.
- R2: A write with `cfg_we` = 1 updates the selected register at the next edge:
  - word index 0x1C0 writes constant A;
  - word index 0x1C1 writes constant B;
  - word index 0x1C2 writes the swizzle word.

  A write to any other index changes none of them.
- R3: In the swizzle word, destination component j takes its 4-bit selector from bits [4j+3:4j]. Selector values 0 to 3 choose source component 0 to 3. Source component k occupies bytes k*S to k*S+S-1 of `in_data`, where S is the component size, least significant byte first.
- R4: Selector 4 yields the low S bytes of constant A, and selector 5 yields the low S bytes of constant B.
- R5: Selector 6 yields an all-zero component and does not raise the error flag.
- R6: A selector of 7 or more, or a source index at or above the source component count, yields a zero component and sets `err`. This applies only to destination components that are produced.
- R7: The swizzle word holds three further fields:
  - bits [17:16] give S = field + 1 bytes;
  - bits [22:20] give the source component count;
  - bits [26:24] give the destination component count.

  A destination count above 4 is treated as 4.
- R8: Destination component j is placed at bytes j*S to j*S+S-1 of `out_data`. `out_bytes` equals the destination count times S. Every byte of `out_data` at or above `out_bytes` is zero.
- R9: A pixel accepted on one edge appears on the output after that edge. `in_ready` = !`out_valid` || `out_ready`. While `out_valid` = 1 and `out_ready` = 0, the output word and `out_bytes` hold, and no pixel is lost or duplicated.
- R10: Each pixel uses the configuration held in the registers on the edge where it is accepted. A register write on that same edge applies only to later pixels.
- R11: Once set, `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Source pixel valid |
| in_ready | output | 1 | Source pixel accepted when high with in_valid |
| in_data | input | 128 | Byte-packed source pixel |
| out_valid | output | 1 | Destination pixel valid |
| out_ready | input | 1 | Downstream can take the destination pixel |
| out_data | output | 128 | Byte-packed destination pixel |
| out_bytes | output | 5 | Destination pixel width in bytes |
| err | output | 1 | Sticky invalid-selection flag |

## Verification
Embedded properties watch four things on every cycle:
- the output word holds steady under backpressure;
- the ready rule holds;
- the error flag never drops and only rises after an accepted pixel;
- no stray bytes sit above the reported destination width.

Whether each selector picks the right bytes, and whether constants are truncated and packed correctly, can only be shown by the bench scenarios. The same holds for register decoding and for the timing of a configuration write against pixel acceptance. The bench compares each output against a byte-by-byte reference model.

// File: rtl/comp_remap.sv
module comp_remap #(
  parameter int NCOMP = 4,
  parameter int CBYTES = 4,
  parameter int AW = 12,
  parameter logic [AW-1:0] ADDR_KA = 12'h1C0,
  parameter logic [AW-1:0] ADDR_KB = 12'h1C1,
  parameter logic [AW-1:0] ADDR_SW = 12'h1C2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [AW-1:0]             cfg_addr,
  input  logic [31:0]               cfg_wdata,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NCOMP*CBYTES*8-1:0] in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [NCOMP*CBYTES*8-1:0] out_data,
  output logic [4:0]                out_bytes,
  output logic                      err
);
  localparam int CW = CBYTES * 8;
  localparam int DW = NCOMP * CW;
  localparam int SHW = $clog2(DW);

  logic [31:0] ka, kb, sw;
  logic [2:0] sz, scnt, dcnt, ndst;
  logic [CW-1:0] mask;
  logic [DW-1:0] placed [NCOMP];
  logic [NCOMP-1:0] bad;
  logic [DW-1:0] packed_px;

  assign sz   = {1'b0, sw[17:16]} + 3'd1;
  assign scnt = sw[22:20];
  assign dcnt = sw[26:24];
  assign ndst = (dcnt > 3'(NCOMP)) ? 3'(NCOMP) : dcnt;
  assign mask = {CW{1'b1}} >> ((CBYTES - int'(sz)) * 8);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ka <= '0;
      kb <= '0;
      sw <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == ADDR_KA) ka <= cfg_wdata;
      if (cfg_addr == ADDR_KB) kb <= cfg_wdata;
      if (cfg_addr == ADDR_SW) sw <= cfg_wdata;
    end
  end

  for (genvar j = 0; j < NCOMP; j++) begin : g_comp
    logic [3:0] sel;
    logic [CW-1:0] raw;
    logic [SHW-1:0] sh;
    logic used;
    assign sel  = sw[4*j +: 4];
    assign used = (3'(j) < ndst);
    assign sh   = SHW'(sel[1:0]) * SHW'(sz) * SHW'(8);
    always_comb begin
      case (sel)
        4'd0, 4'd1, 4'd2, 4'd3: raw = (sel[2:0] < scnt) ? CW'(in_data >> sh) : '0;
        4'd4:    raw = CW'(ka);
        4'd5:    raw = CW'(kb);
        default: raw = '0;
      endcase
    end
    assign bad[j] = used && ((sel >= 4'd7) || (sel < 4'd4 && sel[2:0] >= scnt));
    assign placed[j] = used ? (DW'(raw & mask) << (SHW'(j) * SHW'(sz) * SHW'(8))) : '0;
  end

  always_comb begin
    packed_px = '0;
    for (int j = 0; j < NCOMP; j++) packed_px = packed_px | placed[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_bytes <= '0;
      err       <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= packed_px;
        out_bytes <= 5'(ndst) * 5'(sz);
        err       <= err | (|bad);
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_bytes)); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R11
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(in_valid && in_ready)); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data >> (int'(out_bytes) * 8)) == '0)); // R8
  AST_WIDTH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_bytes <= 5'(NCOMP * CBYTES)); // R8
endmodule

// File: tb/comp_remap_tb_top.sv
`timescale 1ns/1ps
module comp_remap_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [11:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0, err;
  logic [127:0] in_data = 0, out_data;
  logic [4:0] out_bytes;

  int checks = 0, fails = 0;
  logic [31:0] m_ka = 0, m_kb = 0, m_sw = 0;
  logic exp_err = 0;
  logic [127:0] qd[$];
  logic [4:0] qb[$];
  string qt[$];

  always #2.5 clk = ~clk;

  comp_remap dut_i (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_bytes(out_bytes), .err(err));

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [127:0] px, input logic [31:0] k0, input logic [31:0] k1,
                       input logic [31:0] cf, output logic [127:0] d, output logic [4:0] b,
                       output logic e);
    int s, sc, dc;
    s = int'(cf[17:16]) + 1;
    sc = int'(cf[22:20]);
    dc = int'(cf[26:24]);
    if (dc > 4) dc = 4;
    d = '0; e = 0; b = 5'(dc * s);
    for (int j = 0; j < dc; j++) begin
      int sel;
      sel = int'(cf[4*j +: 4]);
      if (sel >= 7 || (sel < 4 && sel >= sc)) e = 1;
      for (int t = 0; t < s; t++) begin
        logic [7:0] v;
        if (sel < 4 && sel < sc) v = px[(sel*s+t)*8 +: 8];
        else if (sel == 4) v = k0[t*8 +: 8];
        else if (sel == 5) v = k1[t*8 +: 8];
        else v = 8'h00;
        d[(j*s+t)*8 +: 8] = v;
      end
    end
  endtask

  task automatic step(input logic iv, input logic [127:0] id, input logic ordy,
                      input logic we, input logic [11:0] wa, input logic [31:0] wd,
                      input string tag);
    logic [127:0] d; logic [4:0] b; logic e;
    @(negedge clk);
    in_valid = iv; in_data = id; out_ready = ordy;
    cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    #1;
    chk("R6 R11 err flag", 128'(err), 128'(exp_err));
    chk("R9 ready rule", 128'(in_ready), 128'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (qd.size() == 0) chk("R9 unexpected output", 1, 0);
      else begin
        chk({tag, " data"}, out_data, qd.pop_front());
        chk({tag, " bytes"}, 128'(out_bytes), 128'(qb.pop_front()));
        void'(qt.pop_front());
      end
    end
    if (in_valid && in_ready) begin
      model(in_data, m_ka, m_kb, m_sw, d, b, e);
      qd.push_back(d); qb.push_back(b); qt.push_back(tag);
      exp_err = exp_err | e;
    end
    if (we) begin
      if (wa == 12'h1C0) m_ka = wd;
      if (wa == 12'h1C1) m_kb = wd;
      if (wa == 12'h1C2) m_sw = wd;
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(0, 0, 1, 1, a, d, "R2");
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, "drain");
    chk("R9 no lost pixel", 128'(qd.size()), 0);
  endtask

  function automatic logic [31:0] mkcfg(input int s, input int sc, input int dc, input logic [15:0] sels);
    return {5'b0, 3'(dc), 1'b0, 3'(sc), 2'b0, 2'(s - 1), sels};
  endfunction

  task automatic burst(input int n, input string tag, input int rdy_pct);
    for (int i = 0; i < n; i++)
      step(($urandom % 4) != 0, rnd128(), ($urandom % 100) < rdy_pct, 0, 0, 0, tag);
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 out_valid", 128'(out_valid), 0);
    chk("R1 in_ready", 128'(in_ready), 1);
    chk("R1 err", 128'(err), 0);
    // R1: zero registers -> size 1, no components
    step(1, rnd128(), 1, 0, 0, 0, "R1");
    drain();

    // R2: decode, stray addresses ignored
    wr(12'h1C0, 32'hA1B2C3D4);
    wr(12'h1C1, 32'h55667788);
    wr(12'h1C3, 32'hFFFFFFFF);
    wr(12'h0C0, 32'h0BADBEEF);
    wr(12'h1C2, mkcfg(4, 4, 2, 16'h0054));
    wr(12'h3C1, 32'h12345678);
    step(1, rnd128(), 1, 0, 0, 0, "R2");
    drain();

    // R3 R7 R8: identity and permutations, every size
    for (int s = 1; s <= 4; s++) begin
      wr(12'h1C2, mkcfg(s, 4, 4, 16'h3210));
      burst(30, "R3 R7 R8 identity", 70);
      wr(12'h1C2, mkcfg(s, 4, 4, 16'h0123));
      burst(30, "R3 R7 R8 reverse", 60);
      wr(12'h1C2, mkcfg(s, 4, 7, 16'h1302));
      burst(20, "R7 R8 dst count clamp", 80);
      wr(12'h1C2, mkcfg(s, 2, 3, 16'h0110));
      burst(20, "R7 R8 narrow dst", 80);
    end
    drain();

    // R4 R5: constants and zero
    for (int s = 1; s <= 4; s++) begin
      wr(12'h1C0, $urandom); wr(12'h1C1, $urandom);
      wr(12'h1C2, mkcfg(s, 4, 4, 16'h6540));
      burst(25, "R4 R5 const zero", 75);
    end
    wr(12'h1C2, mkcfg(2, 4, 1, 16'h7776));
    burst(10, "R5 R8 unused comps ignored", 100);
    drain();

    // R9: long stall then release
    wr(12'h1C2, mkcfg(4, 4, 4, 16'h2301));
    step(1, rnd128(), 0, 0, 0, 0, "R9 stall");
    for (int i = 0; i < 6; i++) step(1, rnd128(), 0, 0, 0, 0, "R9 stall");
    burst(60, "R9 backpressure", 30);
    drain();

    // R10: config writes coinciding with accepts
    for (int i = 0; i < 80; i++) begin
      logic [31:0] c;
      c = mkcfg(($urandom % 4) + 1, 4, $urandom % 8,
                {4'($urandom % 7), 4'($urandom % 7), 4'($urandom % 7), 4'($urandom % 7)});
      step(1, rnd128(), ($urandom % 2) == 0, ($urandom % 2) == 0,
           12'h1C0 + 12'($urandom % 3), ($urandom % 3) == 0 ? $urandom : c, "R10 cfg vs accept");
    end
    drain();

    // R6: invalid selectors, then R11 persistence
    wr(12'h1C2, mkcfg(1, 4, 4, 16'h6543));
    burst(5, "R6 none bad", 100);
    wr(12'h1C2, mkcfg(3, 2, 4, 16'h2010));
    burst(5, "R6 src beyond count", 100);
    drain();
    for (int i = 0; i < 60; i++) begin
      wr(12'h1C2, mkcfg(($urandom % 4) + 1, ($urandom % 5), ($urandom % 8),
                        16'($urandom)));
      burst(4, "R6 random selectors", 70);
    end
    drain();
    wr(12'h1C2, mkcfg(4, 4, 4, 16'h3210));
    burst(20, "R11 stays set", 90);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule